// File: doc/BRIEF.md
# Serial DAC Frame Master

This block sits on the host side of a three-wire serial link to a 16-bit voltage-output DAC. It takes a DAC code and a two-bit output mode from a valid/ready stream. For each accepted word it builds a 24-bit frame and shifts it out on a frame-select line, a serial clock and a data line. The frame carries six zero bits first, then the mode field, then the code, most significant bit first.

The serial clock comes from the system clock. Each high phase and each low phase lasts `HALF_DIV` system cycles, so the serial rate is f_clk / (2·HALF_DIV). `HALF_DIV` must be chosen so that this rate stays within what the converter accepts: 30 MHz or below at the upper supply range, 20 MHz or below at the lower one. The clock idles low. Data changes on each rising edge, so it is settled at the falling edge where the converter samples it.

Between frames the select line is held high for a minimum gap counted in system cycles. An abort input raises the select line part-way through a frame. The converter then discards the partial frame. `busy` shows that a frame is on the wire, and `done` pulses once when a frame completes.

Back-pressure: a word transfers only in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is low from the accepting cycle until the gap after that frame has elapsed. A source may hold `in_valid` and its data for any length of time, and nothing is taken while `in_ready` is low.

Top module: `dac_frame_master`

## Requirements
- R1: After reset, `sync_n` is 1 and `sclk`, `sdo`, `busy`, `done` are 0. `in_ready` is 1.
- R2: A word is accepted only when `in_valid` and `in_ready` are both high. In the next cycle `in_ready` is 0 and `sync_n` is 0. If `in_valid` stays high during a frame, that frame is not re-accepted and its data is not replaced.
- R3: The frame is 24 bits, sent most significant bit first. Bits 23..18 are 0, bits 17..16 carry `in_mode`, and bits 15..0 carry `in_code`.
- R4: While `sync_n` is low, `sdo` changes only in the cycle in which `sclk` rises. It is stable while `sclk` is high and across the falling edge.
- R5: `sclk` is 0 whenever `sync_n` is 1. Every high phase lasts exactly `HALF_DIV` cycles. Every low phase while `sync_n` is low lasts exactly `HALF_DIV` cycles, and this includes the lead-in between the fall of `sync_n` and the first rising edge.
- R6: `sync_n` stays low through all 24 falling edges and rises one cycle after the 24th.
- R7: `done` is high for exactly one cycle, in the cycle right after the 24th falling edge, while `sync_n` is still low. `busy` is 1 whenever `sync_n` is 0.
- R8: Between two frames, `sync_n` stays high for at least `GAP_CYC`+1 cycles. With `in_valid` already waiting, it stays high for exactly that many.
- R9: If `abort` is sampled high while a frame is being clocked, the next cycle has `sync_n`=1 and `sclk`=0. No further falling edge occurs, `done` does not pulse for that frame, and the gap of R8 applies.
- R10: If `abort` is sampled at the same edge that would produce the 24th falling edge, the abort takes priority. Only 23 falling edges happen with `sync_n` low, and `done` does not pulse.
- R11: `abort` has no effect while no frame is in flight: `sync_n` stays 1 and `in_ready` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Word offered on the input stream |
| in_ready | output | 1 | Block can take a word this cycle |
| in_code | input | 16 | DAC code for the frame |
| in_mode | input | 2 | Output mode field for the frame |
| abort | input | 1 | Cut the current frame short |
| sync_n | output | 1 | Frame select, active low |
| sclk | output | 1 | Serial clock, idle low |
| sdo | output | 1 | Serial data, changes on rising edges |
| busy | output | 1 | Frame in flight |
| done | output | 1 | One-cycle pulse when a frame completes |

## Verification
Two functions can fall on the same edge: the abort request and the issuing of the 24th falling edge. The bench watches the serial clock until 23 falls have happened and the last high phase has begun. It then holds `abort` so that it is sampled exactly at the edge that would end that high phase. It judges priority from the pins: `done` must stay silent, the falling-edge count seen while `sync_n` is low must be 23, and the select line must already be high in the next cycle. A normal frame that follows must still come out intact after the gap.

// File: rtl/dac_ser_pkg.sv
package dac_ser_pkg;
  localparam int CODE_W  = 16;
  localparam int MODE_W  = 2;
  localparam int PAD_W   = 6;
  localparam int FRAME_W = PAD_W + MODE_W + CODE_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_HIGH,
    ST_LOW,
    ST_END
  } ser_state_e;

  function automatic logic [FRAME_W-1:0] build_frame(
    input logic [CODE_W-1:0] code,
    input logic [MODE_W-1:0] mode
  );
    return {{PAD_W{1'b0}}, mode, code};
  endfunction
endpackage

// File: rtl/dac_half_timer.sv
module dac_half_timer #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  generate
    if (HALF_DIV <= 1) begin : g_every
      assign tick = run;
    end else begin : g_count
      localparam int CW = $clog2(HALF_DIV);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
          cnt <= '0;
        end else if (cnt == CW'(HALF_DIV-1)) begin
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      assign tick = run && (cnt == CW'(HALF_DIV-1));
    end
  endgenerate
endmodule

// File: rtl/dac_frame_shifter.sv
module dac_frame_shifter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         clear,
  output logic         bit_out
);
  logic [W-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh      <= '0;
      bit_out <= 1'b0;
    end else if (clear) begin
      sh      <= '0;
      bit_out <= 1'b0;
    end else if (load) begin
      sh      <= load_val;
    end else if (shift) begin
      bit_out <= sh[W-1];
      sh      <= {sh[W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/dac_gap_timer.sv
module dac_gap_timer #(
  parameter int GAP_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expired
);
  localparam int CW = $clog2(GAP_CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (start) begin
      cnt <= CW'(GAP_CYC);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/dac_frame_master.sv
module dac_frame_master
  import dac_ser_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int GAP_CYC  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CODE_W-1:0] in_code,
  input  logic [MODE_W-1:0] in_mode,
  input  logic              abort,
  output logic              sync_n,
  output logic              sclk,
  output logic              sdo,
  output logic              busy,
  output logic              done
);
  localparam int FC_W = $clog2(FRAME_W + 1);

  ser_state_e    st;
  logic          sync_q, sclk_q, done_q;
  logic [FC_W-1:0] fall_cnt;
  logic          tick, gap_ok, run;
  logic          accept, in_frame, abort_hit, last_fall;
  logic          shift_now, gap_start;

  assign run       = (st != ST_IDLE);
  assign in_ready  = (st == ST_IDLE) && gap_ok;
  assign accept    = in_valid && in_ready;
  assign in_frame  = (st == ST_LEAD) || (st == ST_HIGH) || (st == ST_LOW);
  assign abort_hit = abort && in_frame;
  assign last_fall = (st == ST_HIGH) && tick && (fall_cnt == FC_W'(FRAME_W-1));
  assign shift_now = tick && ((st == ST_LEAD) || (st == ST_LOW)) && !abort_hit;
  assign gap_start = abort_hit || (st == ST_END);

  dac_half_timer #(.HALF_DIV(HALF_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  dac_frame_shifter #(.W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load(accept), .load_val(build_frame(in_code, in_mode)),
    .shift(shift_now), .clear(gap_start), .bit_out(sdo)
  );

  dac_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk(clk), .rst_n(rst_n), .start(gap_start), .expired(gap_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      sync_q   <= 1'b1;
      sclk_q   <= 1'b0;
      done_q   <= 1'b0;
      fall_cnt <= '0;
    end else begin
      done_q <= 1'b0;
      if (abort_hit) begin
        st     <= ST_IDLE;
        sync_q <= 1'b1;
        sclk_q <= 1'b0;
      end else begin
        case (st)
          ST_IDLE: if (accept) begin
            st       <= ST_LEAD;
            sync_q   <= 1'b0;
            fall_cnt <= '0;
          end
          ST_LEAD, ST_LOW: if (tick) begin
            sclk_q <= 1'b1;
            st     <= ST_HIGH;
          end
          ST_HIGH: if (tick) begin
            sclk_q   <= 1'b0;
            fall_cnt <= fall_cnt + 1'b1;
            if (last_fall) begin
              st     <= ST_END;
              done_q <= 1'b1;
            end else begin
              st <= ST_LOW;
            end
          end
          ST_END: begin
            sync_q <= 1'b1;
            st     <= ST_IDLE;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assign sync_n = sync_q;
  assign sclk   = sclk_q;
  assign done   = done_q;
  assign busy   = run;
endmodule

// File: rtl/dac_frame_master_chk.sv
module dac_frame_master_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic abort,
  input logic sync_n,
  input logic sclk,
  input logic sdo,
  input logic busy,
  input logic done
);
  // R2
  accept_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready && !sync_n);
  // R4
  data_moves_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n && $past(!sync_n) && !$rose(sclk) |-> $stable(sdo));
  // R5
  clock_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_n |-> !sclk);
  // R6
  sync_rises_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> sync_n);
  // R7
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !sync_n ##1 !done);
  // R7
  busy_covers_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n |-> busy);
  // R9
  abort_cuts_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort && !sync_n && !done |=> sync_n && !sclk && !done);
endmodule

bind dac_frame_master dac_frame_master_chk u_chk (.*);

// File: tb/tb_dac_frame_master.sv
module tb_dac_frame_master;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;
  localparam int GAP  = 5;
  localparam int NV   = 6;

  // {code[22:7], mode[6:5], abort_after_falls[4:0]} ; 0 means no abort
  localparam logic [22:0] VECS [NV] = '{
    {16'h0000, 2'b00, 5'd0},
    {16'hFFFF, 2'b11, 5'd0},
    {16'hA5C3, 2'b01, 5'd0},
    {16'h8001, 2'b10, 5'd0},
    {16'h1234, 2'b00, 5'd1},
    {16'h7E7E, 2'b11, 5'd12}
  };

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, abort = 0;
  logic [15:0] in_code = '0;
  logic [1:0]  in_mode = '0;
  logic in_ready, sync_n, sclk, sdo, busy, done;

  int checks = 0, errors = 0;

  dac_frame_master #(.HALF_DIV(HALF), .GAP_CYC(GAP)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .in_mode(in_mode), .abort(abort),
    .sync_n(sync_n), .sclk(sclk), .sdo(sdo), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // pin monitor
  int nfall = 0, last_nfall = 0, done_cnt = 0;
  int hi_cnt = 0, last_gap = 0, hw = 0, lw = 0;
  int v4 = 0, v5 = 0, v7 = 0;
  logic [23:0] cap = '0, last_cap = '0;
  logic p_sync = 1, p_sclk = 0, p_sdo = 0, p_done = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!sync_n && p_sync) begin
        last_gap = hi_cnt; nfall = 0; cap = '0; lw = 0; hw = 0;
      end
      if (sync_n) hi_cnt++; else hi_cnt = 0;
      if (!sync_n && p_sclk && !sclk) begin
        cap = {cap[22:0], sdo}; nfall++;
        if (hw != HALF) v5++;
        hw = 0;
      end
      if (!sync_n && sclk && !p_sclk) begin
        if (lw != HALF) v5++;
        lw = 0;
      end
      if (!sync_n && sclk) hw++;
      if (!sync_n && !sclk) lw++;
      if (sync_n && sclk) v5++;
      if (!sync_n && !p_sync && (sdo != p_sdo) && !(sclk && !p_sclk)) v4++;
      if (done) begin
        done_cnt++;
        if (sync_n || nfall != 24 || p_done) v7++;
      end
      if (!sync_n && !busy) v7++;
      if (sync_n && !p_sync) begin last_nfall = nfall; last_cap = cap; end
      p_sync = sync_n; p_sclk = sclk; p_sdo = sdo; p_done = done;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic wait_ready();
    while (!in_ready) step();
  endtask

  task automatic wait_end();
    while (!sync_n) step();
  endtask

  task automatic run_frame(input logic [15:0] code, input logic [1:0] mode, input int k);
    int d0;
    logic [23:0] fr;
    d0 = done_cnt;
    fr = {6'b0, mode, code};
    wait_ready();
    in_code = code; in_mode = mode; in_valid = 1;
    step();
    in_valid = 0;
    chk(!in_ready && !sync_n, "R2 ready low after accept", {in_ready, sync_n}, 0);
    if (k > 0) begin
      while (nfall != k) step();
      abort = 1; step(); abort = 0;
      chk(sync_n && !sclk, "R9 abort raises sync", {sync_n, sclk}, 2);
    end
    wait_end();
    if (k == 0) begin
      chk(last_nfall == 24, "R6 falls in frame", last_nfall, 24);
      chk(last_cap == fr, "R3 frame content", last_cap, fr);
      chk(done_cnt == d0 + 1, "R7 done once", done_cnt - d0, 1);
    end else begin
      chk(last_nfall == k, "R9 falls before abort", last_nfall, k);
      chk(last_cap[23:0] == 24'(fr >> (24 - k)), "R9 partial bits", last_cap, fr >> (24 - k));
      chk(done_cnt == d0, "R9 no done on abort", done_cnt - d0, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    // R1 reset state
    chk(sync_n == 1, "R1 sync_n", sync_n, 1);
    chk(sclk == 0 && sdo == 0, "R1 sclk/sdo", {sclk, sdo}, 0);
    chk(busy == 0 && done == 0, "R1 busy/done", {busy, done}, 0);
    chk(in_ready == 1, "R1 in_ready", in_ready, 1);

    for (int i = 0; i < NV; i++)
      run_frame(VECS[i][22:7], VECS[i][6:5], int'(VECS[i][4:0]));

    // R8 back-to-back gap exactness
    run_frame(16'h0F0F, 2'b01, 0);
    chk(last_gap == GAP + 1, "R8 sync high gap", last_gap, GAP + 1);

    // R11 abort while idle
    wait_ready();
    abort = 1;
    for (int j = 0; j < 3; j++) begin
      step();
      chk(sync_n && in_ready && !busy, "R11 idle abort ignored", {sync_n, in_ready, busy}, 6);
    end
    abort = 0;
    run_frame(16'h5A5A, 2'b10, 0);

    // R2 back-pressure: hold valid across a frame
    wait_ready();
    in_code = 16'hC001; in_mode = 2'b01; in_valid = 1;
    step();
    in_code = 16'h3EE3; in_mode = 2'b10;
    chk(!in_ready, "R2 ready low while busy", in_ready, 0);
    wait_end();
    chk(last_cap == {6'b0, 2'b01, 16'hC001}, "R2 first word intact", last_cap, {6'b0, 2'b01, 16'hC001});
    while (sync_n) step();
    in_valid = 0;
    chk(last_gap == GAP + 1, "R8 gap with waiting source", last_gap, GAP + 1);
    wait_end();
    chk(last_cap == {6'b0, 2'b10, 16'h3EE3}, "R2 second word", last_cap, {6'b0, 2'b10, 16'h3EE3});

    // R10 abort on the edge of the 24th fall
    begin
      int d0;
      d0 = done_cnt;
      wait_ready();
      in_code = 16'hBEEF; in_mode = 2'b11; in_valid = 1;
      step(); in_valid = 0;
      while (!(nfall == 23 && sclk)) step();
      repeat (HALF - 1) step();
      abort = 1; step(); abort = 0;
      chk(sync_n == 1, "R10 sync high after collision", sync_n, 1);
      wait_end();
      chk(last_nfall == 23, "R10 falls seen", last_nfall, 23);
      chk(done_cnt == d0, "R10 done suppressed", done_cnt - d0, 0);
    end
    run_frame(16'h0001, 2'b00, 0);

    // pin-rule monitors
    chk(v4 == 0, "R4 data change only on rise", v4, 0);
    chk(v5 == 0, "R5 clock phase widths", v5, 0);
    chk(v7 == 0, "R7 done/busy timing", v7, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule